// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block tracks one load-linked reservation and one locked read-modify-write queue block for a cache controller. Each cycle, the block can receive one write-class completion. A completion carries a line address, a requester ID, an operation code and a flag that says whether the line is present in the cache. A load-linked completion records which requester reserved which line. A store-conditional completion tests that reservation, returns a pass or fail bit, and then drops the reservation for its line. An ordinary write from the reservation owner to a present, reserved line also drops the reservation.

Locked read-modify-write pairs drive a second function. The read half produces a command that blocks the request queue for its line. The write half produces a command that unblocks it. Only one line may be blocked at a time, and a second locked read while a line is blocked raises an error pulse. An external clear port models loss of a line and drops a matching reservation. A test-bypass input stops all reservation handling and forces every store-conditional to pass.

The completion port is an event stream without back-pressure: `cmp_valid` qualifies a completion, and the block accepts it in that cycle. It has no ready signal. Every result is a one-cycle registered pulse that appears on the cycle after the completion.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked completion (`cmp_kind` = 1) records a reservation for its line and requester. A later store-conditional from the same requester to the same line passes.
- R2: A store-conditional completion (`cmp_kind` = 2) raises `sc_valid` for one cycle on the next cycle. `sc_success` is 1 only when a reservation is held for that line by that requester. A store-conditional that does not match the line or the requester reports 0.
- R3: Every store-conditional drops a reservation held on its line, whether it passes or fails. A store-conditional to another line leaves the reservation in place.
- R4: An ordinary write-class completion clears the reservation only when it hits the reserved line, comes from the reservation owner, and has `cmp_present` = 1. Ordinary write-class codes are 0, 5, 6 and 7; codes 3 and 4 are also write-class. The same write from another requester, or with `cmp_present` = 0, leaves the reservation intact.
- R5: A locked read completion (`cmp_kind` = 3) with no line blocked pulses `qblk_valid` on the next cycle, with `cmd_line` equal to its line.
- R6: A locked write completion (`cmp_kind` = 4) pulses `qunblk_valid` on the next cycle, with `cmd_line` equal to its line, and releases the block if the line matches.
- R7: While `test_bypass` = 1, every store-conditional reports success and no completion changes the reservation.
- R8: `clr_valid` with `clr_line` equal to the reserved line drops the reservation, and a clear to another line is ignored. The clear takes effect before a completion in the same cycle, so a load-linked in that cycle still sets a reservation.
- R9: A new load-linked replaces any earlier reservation.
- R10: A locked read that arrives while a line is blocked pulses `proto_err` on the next cycle. It issues no block command and keeps the current block.
- R11: After reset, all outputs are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion strobe |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_id | input | ID_W | Requester ID |
| cmp_kind | input | 3 | Operation code: 0 store, 1 load-linked, 2 store-conditional, 3 locked read, 4 locked write, 5 flush, 6 and 7 treated as store |
| cmp_present | input | 1 | Line present in the cache |
| test_bypass | input | 1 | Bypass reservation handling |
| clr_valid | input | 1 | Drop reservation for `clr_line` |
| clr_line | input | LINE_W | Line lost to an outside agent |
| sc_valid | output | 1 | Store-conditional result is valid |
| sc_success | output | 1 | Store-conditional result |
| qblk_valid | output | 1 | Block request queue for `cmd_line` |
| qunblk_valid | output | 1 | Unblock request queue for `cmd_line` |
| cmd_line | output | LINE_W | Line address of the completion that produced the pulse |
| proto_err | output | 1 | Locked read arrived while a line was already blocked |

## Verification
A wrong reservation register is only visible at the ports on the next store-conditional. A reservation that was dropped too early, or kept too long, turns into a wrong `sc_success` one cycle after that store-conditional. For this reason, the stimulus follows every action that changes the reservation with a store-conditional that tests it. A wrong blocked-line flag shows up one cycle after the next locked read, as a missing block command or a false `proto_err`.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    OP_STORE = 3'd0,
    OP_LL    = 3'd1,
    OP_SC    = 3'd2,
    OP_LKRD  = 3'd3,
    OP_LKWR  = 3'd4,
    OP_FLUSH = 3'd5
  } op_kind_e;
endpackage

// File: rtl/llsc_resv_track.sv
module llsc_resv_track
  import llsc_mon_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [KIND_W-1:0] cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [ID_W-1:0]   cmp_id,
  input  logic              cmp_present,
  input  logic              bypass,
  input  logic              clr_valid,
  input  logic [LINE_W-1:0] clr_line,
  output logic              sc_pass,
  output logic              resv_valid
);
  logic              vld_q;
  logic [LINE_W-1:0] line_q;
  logic [ID_W-1:0]   id_q;
  logic              vld_eff;
  logic              line_hit;
  logic              owner_hit;
  logic              vld_d;
  logic [LINE_W-1:0] line_d;
  logic [ID_W-1:0]   id_d;

  // the outside clear is applied before the completion in the same cycle
  assign vld_eff   = vld_q && !(clr_valid && (clr_line == line_q));
  assign line_hit  = vld_eff && (line_q == cmp_line);
  assign owner_hit = line_hit && (id_q == cmp_id);
  assign sc_pass   = bypass || owner_hit;

  always_comb begin
    vld_d  = vld_eff;
    line_d = line_q;
    id_d   = id_q;
    if (cmp_valid && !bypass) begin
      unique case (cmp_kind)
        OP_LL: begin
          vld_d  = 1'b1;
          line_d = cmp_line;
          id_d   = cmp_id;
        end
        OP_SC: begin
          if (line_hit) vld_d = 1'b0;
        end
        default: begin
          if (cmp_present && owner_hit) vld_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      line_q <= '0;
      id_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      line_q <= line_d;
      id_q   <= id_d;
    end
  end

  assign resv_valid = vld_q;
endmodule

// File: rtl/llsc_qlock_ctl.sv
module llsc_qlock_ctl #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_rd,
  input  logic              lk_wr,
  input  logic [LINE_W-1:0] line,
  output logic              blk_req,
  output logic              unblk_req,
  output logic              dup_err,
  output logic              blocked
);
  logic              blk_q;
  logic [LINE_W-1:0] blk_line_q;

  assign blk_req   = lk_rd && !blk_q;
  assign dup_err   = lk_rd && blk_q;
  assign unblk_req = lk_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q      <= 1'b0;
      blk_line_q <= '0;
    end else if (blk_req) begin
      blk_q      <= 1'b1;
      blk_line_q <= line;
    end else if (lk_wr && blk_q && (blk_line_q == line)) begin
      blk_q <= 1'b0;
    end
  end

  assign blocked = blk_q;
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_mon_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [ID_W-1:0]   cmp_id,
  input  logic [KIND_W-1:0] cmp_kind,
  input  logic              cmp_present,
  input  logic              test_bypass,
  input  logic              clr_valid,
  input  logic [LINE_W-1:0] clr_line,
  output logic              sc_valid,
  output logic              sc_success,
  output logic              qblk_valid,
  output logic              qunblk_valid,
  output logic [LINE_W-1:0] cmd_line,
  output logic              proto_err
);
  logic is_sc;
  logic is_lkrd;
  logic is_lkwr;
  logic sc_pass;
  logic resv_valid;
  logic blk_req;
  logic unblk_req;
  logic dup_err;
  logic blocked;

  assign is_sc   = cmp_valid && (cmp_kind == OP_SC);
  assign is_lkrd = cmp_valid && (cmp_kind == OP_LKRD);
  assign is_lkwr = cmp_valid && (cmp_kind == OP_LKWR);

  llsc_resv_track #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid   (cmp_valid),
    .cmp_kind    (cmp_kind),
    .cmp_line    (cmp_line),
    .cmp_id      (cmp_id),
    .cmp_present (cmp_present),
    .bypass      (test_bypass),
    .clr_valid   (clr_valid),
    .clr_line    (clr_line),
    .sc_pass     (sc_pass),
    .resv_valid  (resv_valid)
  );

  llsc_qlock_ctl #(.LINE_W(LINE_W)) u_qlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_rd     (is_lkrd),
    .lk_wr     (is_lkwr),
    .line      (cmp_line),
    .blk_req   (blk_req),
    .unblk_req (unblk_req),
    .dup_err   (dup_err),
    .blocked   (blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_valid     <= 1'b0;
      sc_success   <= 1'b0;
      qblk_valid   <= 1'b0;
      qunblk_valid <= 1'b0;
      proto_err    <= 1'b0;
      cmd_line     <= '0;
    end else begin
      sc_valid     <= is_sc;
      sc_success   <= is_sc && sc_pass;
      qblk_valid   <= blk_req;
      qunblk_valid <= unblk_req;
      proto_err    <= dup_err;
      if (cmp_valid) cmd_line <= cmp_line;
    end
  end
endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk
  import llsc_mon_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic [KIND_W-1:0] cmp_kind,
  input logic [LINE_W-1:0] cmp_line,
  input logic              test_bypass,
  input logic              clr_valid,
  input logic              resv_valid,
  input logic              blocked,
  input logic              sc_valid,
  input logic              sc_success,
  input logic              qblk_valid,
  input logic              qunblk_valid,
  input logic [LINE_W-1:0] cmd_line,
  input logic              proto_err
);
  AST_LL_SETS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_LL && !test_bypass |=> resv_valid); // R1
  AST_SC_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_SC |=> sc_valid); // R2
  AST_SC_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_SC && !resv_valid && !test_bypass |=> !sc_success); // R2
  AST_SC_RESULT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    sc_success |-> sc_valid); // R2
  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_SC && test_bypass |=> sc_success); // R7
  AST_BYPASS_HOLDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    test_bypass && !clr_valid |=> $stable(resv_valid)); // R7
  AST_BLOCK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_LKRD && !blocked |=> qblk_valid && cmd_line == $past(cmp_line)); // R5
  AST_UNBLOCK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_LKWR |=> qunblk_valid && cmd_line == $past(cmp_line)); // R6
  AST_DUP_BLOCK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == OP_LKRD && blocked |=> proto_err && !qblk_valid && blocked); // R10
  AST_ONE_QUEUE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({qblk_valid, qunblk_valid, proto_err})); // R10
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_valid    (cmp_valid),
  .cmp_kind     (cmp_kind),
  .cmp_line     (cmp_line),
  .test_bypass  (test_bypass),
  .clr_valid    (clr_valid),
  .resv_valid   (resv_valid),
  .blocked      (blocked),
  .sc_valid     (sc_valid),
  .sc_success   (sc_success),
  .qblk_valid   (qblk_valid),
  .qunblk_valid (qunblk_valid),
  .cmd_line     (cmd_line),
  .proto_err    (proto_err)
);

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;
  localparam int LINE_W = 26;
  localparam int ID_W   = 4;
  localparam int NVEC   = 28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_valid = 1'b0;
  logic [LINE_W-1:0] cmp_line = '0;
  logic [ID_W-1:0]   cmp_id = '0;
  logic [2:0]        cmp_kind = '0;
  logic              cmp_present = 1'b0;
  logic              test_bypass = 1'b0;
  logic              clr_valid = 1'b0;
  logic [LINE_W-1:0] clr_line = '0;
  logic              sc_valid, sc_success, qblk_valid, qunblk_valid, proto_err;
  logic [LINE_W-1:0] cmd_line;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  llsc_resv_monitor #(.LINE_W(LINE_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_line(cmp_line),
    .cmp_id(cmp_id), .cmp_kind(cmp_kind), .cmp_present(cmp_present),
    .test_bypass(test_bypass), .clr_valid(clr_valid), .clr_line(clr_line),
    .sc_valid(sc_valid), .sc_success(sc_success), .qblk_valid(qblk_valid),
    .qunblk_valid(qunblk_valid), .cmd_line(cmd_line), .proto_err(proto_err)
  );

  // fields: req[25:22] kind[21:19] line[18:11] id[10:7] present[6] bypass[5]
  // expected[4:0] = {sc_valid, sc_success, qblk_valid, qunblk_valid, proto_err}
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {4'd1,  3'd1, 8'h10, 4'd1, 1'b0, 1'b0, 5'b00000}, // R1 load-linked
    {4'd1,  3'd2, 8'h10, 4'd1, 1'b0, 1'b0, 5'b11000}, // R1 pass
    {4'd3,  3'd2, 8'h10, 4'd1, 1'b0, 1'b0, 5'b10000}, // R3 cleared by pass
    {4'd1,  3'd1, 8'h20, 4'd2, 1'b0, 1'b0, 5'b00000},
    {4'd2,  3'd2, 8'h20, 4'd3, 1'b0, 1'b0, 5'b10000}, // R2 wrong requester
    {4'd3,  3'd2, 8'h20, 4'd2, 1'b0, 1'b0, 5'b10000}, // R3 cleared by fail
    {4'd1,  3'd1, 8'h30, 4'd1, 1'b0, 1'b0, 5'b00000},
    {4'd2,  3'd2, 8'h31, 4'd1, 1'b0, 1'b0, 5'b10000}, // R2 wrong line
    {4'd3,  3'd2, 8'h30, 4'd1, 1'b0, 1'b0, 5'b11000}, // R3 other line kept
    {4'd1,  3'd1, 8'h40, 4'd1, 1'b0, 1'b0, 5'b00000},
    {4'd4,  3'd0, 8'h40, 4'd2, 1'b1, 1'b0, 5'b00000}, // R4 other requester
    {4'd4,  3'd5, 8'h40, 4'd1, 1'b0, 1'b0, 5'b00000}, // R4 line absent
    {4'd4,  3'd2, 8'h40, 4'd1, 1'b0, 1'b0, 5'b11000}, // R4 still held
    {4'd1,  3'd1, 8'h40, 4'd1, 1'b0, 1'b0, 5'b00000},
    {4'd4,  3'd0, 8'h40, 4'd1, 1'b1, 1'b0, 5'b00000}, // R4 owner store
    {4'd4,  3'd2, 8'h40, 4'd1, 1'b0, 1'b0, 5'b10000}, // R4 cleared
    {4'd9,  3'd1, 8'h50, 4'd1, 1'b0, 1'b0, 5'b00000},
    {4'd9,  3'd1, 8'h60, 4'd1, 1'b0, 1'b0, 5'b00000}, // R9 replace
    {4'd9,  3'd2, 8'h50, 4'd1, 1'b0, 1'b0, 5'b10000}, // R9 old line gone
    {4'd9,  3'd2, 8'h60, 4'd1, 1'b0, 1'b0, 5'b11000}, // R9 new line held
    {4'd7,  3'd2, 8'h70, 4'd5, 1'b0, 1'b1, 5'b11000}, // R7 forced pass
    {4'd7,  3'd1, 8'h70, 4'd5, 1'b0, 1'b1, 5'b00000}, // R7 no reservation set
    {4'd7,  3'd2, 8'h70, 4'd5, 1'b0, 1'b0, 5'b10000}, // R7 confirmed
    {4'd5,  3'd3, 8'h80, 4'd1, 1'b1, 1'b0, 5'b00100}, // R5 block
    {4'd10, 3'd3, 8'h90, 4'd2, 1'b1, 1'b0, 5'b00001}, // R10 second lock
    {4'd6,  3'd4, 8'h80, 4'd1, 1'b1, 1'b0, 5'b00010}, // R6 unblock
    {4'd10, 3'd3, 8'h90, 4'd2, 1'b1, 1'b0, 5'b00100}, // R10 released
    {4'd6,  3'd4, 8'h90, 4'd2, 1'b1, 1'b0, 5'b00010}  // R6 unblock
  };

  function automatic logic [4:0] outs();
    return {sc_valid, sc_success, qblk_valid, qunblk_valid, proto_err};
  endfunction

  task automatic check(input int req, input string what, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b exp %b", req, what, got, exp);
    end
  endtask

  // called at a negedge; drives one completion and samples after the next edge
  task automatic step(input logic [2:0] k, input logic [7:0] ln, input logic [3:0] id,
                      input logic pres, input logic byp,
                      input logic cv, input logic [7:0] cl);
    cmp_valid   = 1'b1;
    cmp_kind    = k;
    cmp_line    = LINE_W'(ln);
    cmp_id      = id;
    cmp_present = pres;
    test_bypass = byp;
    clr_valid   = cv;
    clr_line    = LINE_W'(cl);
    @(negedge clk);
    cmp_valid   = 1'b0;
    clr_valid   = 1'b0;
    test_bypass = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(11, "reset outputs", outs(), 5'b00000); // R11
    rst_n = 1'b1;
    @(negedge clk);
    check(11, "idle after reset", outs(), 5'b00000); // R11

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21:19], VEC[i][18:11], VEC[i][10:7], VEC[i][6], VEC[i][5], 1'b0, 8'h00);
      check(int'(VEC[i][25:22]), $sformatf("vector %0d", i), outs(), VEC[i][4:0]);
      if (VEC[i][1] || VEC[i][2]) begin
        total++;
        if (cmd_line !== LINE_W'(VEC[i][18:11])) begin
          bad++;
          $display("FAIL R%0d vector %0d cmd_line: got %h exp %h", VEC[i][25:22], i,
                   cmd_line, LINE_W'(VEC[i][18:11]));
        end
      end
    end

    // R8: clear to a different line is ignored
    step(3'd1, 8'hA0, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    step(3'd0, 8'hC0, 4'd9, 1'b0, 1'b0, 1'b1, 8'hA1);
    step(3'd2, 8'hA0, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    check(8, "clear other line", outs(), 5'b11000);
    // R8: matching clear drops the reservation
    step(3'd1, 8'hA0, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    step(3'd0, 8'hC0, 4'd9, 1'b0, 1'b0, 1'b1, 8'hA0);
    step(3'd2, 8'hA0, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    check(8, "clear same line", outs(), 5'b10000);
    // R8: load-linked in the same cycle as a matching clear wins
    step(3'd1, 8'hB0, 4'd2, 1'b0, 1'b0, 1'b0, 8'h00);
    step(3'd1, 8'hB0, 4'd2, 1'b0, 1'b0, 1'b1, 8'hB0);
    step(3'd2, 8'hB0, 4'd2, 1'b0, 1'b0, 1'b0, 8'h00);
    check(8, "clear with load-linked", outs(), 5'b11000);
    // R11: reset drops a reservation and a block
    step(3'd1, 8'hD0, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00);
    step(3'd3, 8'hE0, 4'd3, 1'b1, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check(11, "outputs in reset", outs(), 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    step(3'd2, 8'hD0, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00);
    check(11, "reservation after reset", outs(), 5'b10000);
    step(3'd3, 8'hF0, 4'd3, 1'b1, 1'b0, 1'b0, 8'h00);
    check(11, "block after reset", outs(), 5'b00100);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule